// File: doc/BRIEF.md
# Stable Array Packing Unit

This block holds a small array of data words, each tagged with a one-bit mark. It reorders the array so that every marked word sits at the front and every unmarked word follows. Each of the two groups keeps the relative order it had when loaded. The words and their marks are written into an internal buffer one at a time. A start pulse runs the packing operation. When the reordered array is ready, a one-cycle done pulse appears, and the result can be read back through an asynchronous read port.

Each word's destination comes from two exclusive prefix counts, each built with a logarithmic doubling scan:

- **First count, over the marks.** It places the marked words. Its final total, the number of marked words, is kept on an output.
- **Second count, over the inverted marks.** It places the unmarked words, offset by that total.

A single scatter step then moves every word to its destination at once. The array length must be a power of two.

Top module: `stable_pack_unit`

## Requirements
- R1: After reset, `busy`, `done` and `markCount` are all 0.
- R2: While `busy` is low, a cycle with `wrEn` high stores `wrData` and `wrMark` at index `wrAddr`. `rdData` and `rdMark` show the stored word and mark at index `rdAddr` combinationally.
- R3: After packing, index j for j < m holds the j-th marked word in load order, where m is the number of marked words.
- R4: After packing, index m + k holds the k-th unmarked word in load order.
- R5: From the done pulse onward, `markCount` equals the number of words whose mark was 1 when the operation started.
- R6: `done` is high for exactly one cycle, in the cycle after the 2*log2(N)+5-th rising edge that follows the edge sampling `start`.
- R7: `busy` is high from the edge that samples `start` through the done cycle inclusive. While `busy` is high, `start` and `wrEn` are ignored: the result and the timing are unchanged.
- R8: When no word is marked, or every word is marked, the packed array equals the loaded array.
- R9: After packing, `rdMark` is 1 at indices 0..m-1 and 0 at indices m..N-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Load strobe for one element |
| wrAddr | input | log2(N) | Element index to load |
| wrData | input | DATA_W | Data word to load |
| wrMark | input | 1 | Mark bit to load |
| start | input | 1 | Begin packing (sampled while idle) |
| rdAddr | input | log2(N) | Element index to read |
| rdData | output | DATA_W | Data word at `rdAddr` |
| rdMark | output | 1 | Mark bit at `rdAddr` |
| busy | output | 1 | Packing operation in progress |
| done | output | 1 | One-cycle completion pulse |
| markCount | output | log2(N)+1 | Number of marked elements |

## Verification
The bench builds the block with NUM_ELEM = 8 and DATA_W = 8. With eight lanes there are only 256 mark patterns, so every one of them is run, each with fresh random data words. This covers the empty and full cases, a single mark at either end, and every interleaving of groups. With a three-step scan, the latency check exercises every stride of both doubling passes. Some trials also drive writes and extra start pulses mid-operation, to show that they leave no trace.

// File: rtl/pack_pkg.sv
package pack_pkg;
  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic ldFlags;      // load flag vector from marks
    logic invFlags;     // invert marks while loading
    logic scanStep;     // one doubling step of the prefix scan
    logic saveMarked;   // capture marked destinations and total
    logic saveUnmarked; // capture unmarked destinations
    logic scatter;      // move every element to its destination
  } pack_ctl_t;
endpackage

// File: rtl/pack_ctrl.sv
module pack_ctrl
  import pack_pkg::*;
#(
  parameter int LOG_N = 3,
  localparam int SW = (LOG_N > 1) ? $clog2(LOG_N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output pack_ctl_t     ctl,
  output logic [SW-1:0] stepIdx,
  output logic          busy,
  output logic          done
);
  typedef enum logic [3:0] {
    S_IDLE, S_LOAD1, S_SCAN1, S_SAVE1, S_LOAD2, S_SCAN2, S_SAVE2, S_SCAT, S_FIN
  } state_t;

  state_t state, stateNxt;
  logic [SW-1:0] stepCnt;
  logic lastStep;

  assign lastStep = (stepCnt == SW'(LOG_N - 1));
  assign stepIdx  = stepCnt;
  assign busy     = (state != S_IDLE);
  assign done     = (state == S_FIN);

  always_comb begin
    stateNxt = state;
    case (state)
      S_IDLE:  if (start) stateNxt = S_LOAD1;
      S_LOAD1: stateNxt = S_SCAN1;
      S_SCAN1: if (lastStep) stateNxt = S_SAVE1;
      S_SAVE1: stateNxt = S_LOAD2;
      S_LOAD2: stateNxt = S_SCAN2;
      S_SCAN2: if (lastStep) stateNxt = S_SAVE2;
      S_SAVE2: stateNxt = S_SCAT;
      S_SCAT:  stateNxt = S_FIN;
      S_FIN:   stateNxt = S_IDLE;
      default: stateNxt = S_IDLE;
    endcase
  end

  always_comb begin
    ctl = '0;
    case (state)
      S_LOAD1: ctl.ldFlags = 1'b1;
      S_SCAN1: ctl.scanStep = 1'b1;
      S_SAVE1: ctl.saveMarked = 1'b1;
      S_LOAD2: begin
        ctl.ldFlags  = 1'b1;
        ctl.invFlags = 1'b1;
      end
      S_SCAN2: ctl.scanStep = 1'b1;
      S_SAVE2: ctl.saveUnmarked = 1'b1;
      S_SCAT:  ctl.scatter = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      stepCnt <= '0;
    end else begin
      state <= stateNxt;
      if (ctl.scanStep) stepCnt <= lastStep ? '0 : stepCnt + SW'(1);
    end
  end

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  done_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  // R7
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy);

  // R7
  done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
endmodule

// File: rtl/pack_datapath.sv
module pack_datapath
  import pack_pkg::*;
#(
  parameter int NUM_ELEM = 8,
  parameter int DATA_W   = 8,
  localparam int IDX_W = $clog2(NUM_ELEM),
  localparam int CNT_W = IDX_W + 1,
  localparam int SW    = (IDX_W > 1) ? $clog2(IDX_W) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  pack_ctl_t         ctl,
  input  logic [SW-1:0]     stepIdx,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrMark,
  input  logic [IDX_W-1:0]  rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              rdMark,
  output logic [CNT_W-1:0]  markCount
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [DATA_W-1:0] dataBuf [NUM_ELEM];
  logic [DATA_W-1:0] dataNxt [NUM_ELEM];
  logic [NUM_ELEM-1:0] markBuf, markNxt;
  logic [CNT_W-1:0] pre [NUM_ELEM];
  logic [CNT_W-1:0] preNxt [NUM_ELEM];
  logic [IDX_W-1:0] dest [NUM_ELEM];
  int stride;

  assign rdData = dataBuf[rdAddr];
  assign rdMark = markBuf[rdAddr];
  assign stride = 1 << stepIdx;

  // Flag load and doubling scan step (inclusive counts)
  always_comb begin
    for (int i = 0; i < NUM_ELEM; i++) begin
      if (ctl.ldFlags)
        preNxt[i] = {{(CNT_W-1){1'b0}}, markBuf[i] ^ ctl.invFlags};
      else if (ctl.scanStep && i >= stride)
        preNxt[i] = pre[i] + pre[i - stride];
      else
        preNxt[i] = pre[i];
    end
  end

  // Scatter network: each element lands on its own destination
  always_comb begin
    dataNxt = dataBuf;
    markNxt = markBuf;
    for (int i = 0; i < NUM_ELEM; i++) begin
      dataNxt[dest[i]] = dataBuf[i];
      markNxt[dest[i]] = markBuf[i];
    end
  end

  always_ff @(posedge clk) begin
    pre <= preNxt;
    for (int i = 0; i < NUM_ELEM; i++) begin
      if (ctl.saveMarked && markBuf[i])
        dest[i] <= IDX_W'(pre[i] - ONE);
      else if (ctl.saveUnmarked && !markBuf[i])
        dest[i] <= IDX_W'(pre[i] - ONE + markCount);
    end
    if (wrEn) begin
      dataBuf[wrAddr] <= wrData;
      markBuf[wrAddr] <= wrMark;
    end else if (ctl.scatter) begin
      dataBuf <= dataNxt;
      markBuf <= markNxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) markCount <= '0;
    else if (ctl.saveMarked) markCount <= pre[NUM_ELEM-1];
  end

  // R4
  unmarked_total_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.saveUnmarked |-> (pre[NUM_ELEM-1] + markCount == CNT_W'(NUM_ELEM)));

  // R5
  count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    markCount <= CNT_W'(NUM_ELEM));

  // R7
  no_write_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.scatter |-> !wrEn);
endmodule

// File: rtl/stable_pack_unit.sv
module stable_pack_unit
  import pack_pkg::*;
#(
  parameter int NUM_ELEM = 8,
  parameter int DATA_W   = 8,
  localparam int IDX_W = $clog2(NUM_ELEM),
  localparam int CNT_W = IDX_W + 1,
  localparam int SW    = (IDX_W > 1) ? $clog2(IDX_W) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrMark,
  input  logic              start,
  input  logic [IDX_W-1:0]  rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              rdMark,
  output logic              busy,
  output logic              done,
  output logic [CNT_W-1:0]  markCount
);
  pack_ctl_t ctl;
  logic [SW-1:0] stepIdx;
  logic wrGated;

  assign wrGated = wrEn && !busy;

  pack_ctrl #(.LOG_N(IDX_W)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .ctl(ctl), .stepIdx(stepIdx), .busy(busy), .done(done)
  );

  pack_datapath #(.NUM_ELEM(NUM_ELEM), .DATA_W(DATA_W)) i_dp (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .stepIdx(stepIdx),
    .wrEn(wrGated), .wrAddr(wrAddr), .wrData(wrData), .wrMark(wrMark),
    .rdAddr(rdAddr), .rdData(rdData), .rdMark(rdMark), .markCount(markCount)
  );
endmodule

// File: tb/test_stable_pack_unit.sv
module test_stable_pack_unit;
  localparam int N = 8;
  localparam int W = 8;
  localparam int IW = $clog2(N);
  localparam int LAT = 2 * IW + 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wrEn = 1'b0;
  logic [IW-1:0] wrAddr = '0;
  logic [W-1:0] wrData = '0;
  logic wrMark = 1'b0;
  logic start = 1'b0;
  logic [IW-1:0] rdAddr = '0;
  logic [W-1:0] rdData;
  logic rdMark;
  logic busy, done;
  logic [IW:0] markCount;

  int total = 0;
  int bad = 0;
  logic [W-1:0] curData [N];
  logic curMark [N];
  logic [W-1:0] expData [N];
  logic expMark [N];
  int expCount;

  always #4 clk = ~clk;

  stable_pack_unit #(.NUM_ELEM(N), .DATA_W(W)) i_stable_pack_unit (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .wrMark(wrMark), .start(start), .rdAddr(rdAddr), .rdData(rdData),
    .rdMark(rdMark), .busy(busy), .done(done), .markCount(markCount)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Expected packed order, built by walking the array twice
  task automatic computeExpected();
    int pos = 0;
    for (int i = 0; i < N; i++)
      if (curMark[i]) begin expData[pos] = curData[i]; expMark[pos] = 1'b1; pos++; end
    expCount = pos;
    for (int i = 0; i < N; i++)
      if (!curMark[i]) begin expData[pos] = curData[i]; expMark[pos] = 1'b0; pos++; end
  endtask

  task automatic loadArray();
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      wrEn = 1'b1; wrAddr = IW'(i); wrData = curData[i]; wrMark = curMark[i];
    end
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic runPack(input bit poke);
    int lat = 0;
    @(negedge clk);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R7 busy after start", int'(busy), 1);
    while (!done && lat < 100) begin
      if (poke && lat == 2) begin
        wrEn = 1'b1; wrAddr = '0; wrData = ~curData[0]; wrMark = ~curMark[0]; start = 1'b1;
      end
      @(posedge clk);
      @(negedge clk);
      wrEn = 1'b0; start = 1'b0;
      lat++;
    end
    check(lat == LAT, poke ? "R7 latency with pokes" : "R6 done latency", lat, LAT);
    @(negedge clk);
    check(done == 1'b0, "R6 done single cycle", int'(done), 0);
    check(busy == 1'b0, "R7 busy released", int'(busy), 0);
  endtask

  task automatic checkResult();
    check(int'(markCount) == expCount, "R5 markCount", int'(markCount), expCount);
    for (int i = 0; i < N; i++) begin
      rdAddr = IW'(i);
      #1;
      if (i < expCount)
        check(rdData == expData[i], "R3 marked order", int'(rdData), int'(expData[i]));
      else
        check(rdData == expData[i], "R4 unmarked order", int'(rdData), int'(expData[i]));
      check(rdMark == expMark[i], "R9 mark layout", int'(rdMark), int'(expMark[i]));
      if (expCount == 0 || expCount == N)
        check(rdData == curData[i], "R8 identity", int'(rdData), int'(curData[i]));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1 reset state
    check(busy == 1'b0, "R1 busy", int'(busy), 0);
    check(done == 1'b0, "R1 done", int'(done), 0);
    check(markCount == '0, "R1 markCount", int'(markCount), 0);
    rst_n = 1'b1;

    // R2 write and read back before packing
    for (int i = 0; i < N; i++) begin curData[i] = W'(8'h30 + i); curMark[i] = i[0]; end
    loadArray();
    for (int i = 0; i < N; i++) begin
      rdAddr = IW'(i);
      #1;
      check(rdData == curData[i], "R2 readback data", int'(rdData), int'(curData[i]));
      check(rdMark == curMark[i], "R2 readback mark", int'(rdMark), int'(curMark[i]));
    end

    // Every mark pattern with random words; some trials poke while busy
    for (int pat = 0; pat < (1 << N); pat++) begin
      for (int i = 0; i < N; i++) begin
        curData[i] = W'($urandom);
        curMark[i] = pat[i];
      end
      computeExpected();
      loadArray();
      runPack((pat % 16) == 5);
      checkResult();
    end

    // Repacking an already packed array keeps it unchanged
    for (int i = 0; i < N; i++) begin curData[i] = expData[i]; curMark[i] = expMark[i]; end
    computeExpected();
    runPack(1'b0);
    checkResult();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule